// File: doc/BRIEF.md
# Serial Converter Timing and Power-Mode Controller

This block is the digital control core of a 14-bit sampling converter that has a serial output. It takes a convert-start strobe and a serial clock from outside, both asynchronous to its own fast system clock. A convert strobe commands the sample-and-hold into hold and starts a step sequencer. The sequencer is advanced by serial clock edges. When the last step completes, the word on the quantizer input bus is captured. The same serial clock edges shift out, most significant bit first, the two's complement word that the previous conversion produced. Shifting uses a data line and an enable, so that the pad can release the line to high impedance.

When the serial clock stays still, convert strobes are counted instead, and the count selects a low-power state. Two or three strobes give the light nap state, and four or more give the deep sleep state. Sleep ends on any serial clock edge. Nap ends only when a convert strobe is followed by serial clock activity. A strobe that enters a power state abandons the conversion it interrupts, and the last completed result is kept.

Top module: `adcctl_top`

## Requirements
- R1: A convert rising edge in run state, with no convert edge since the last serial clock edge, raises `hold`. `hold` falls on the CONV_STEPS-th (14) serial clock rising edge after that strobe.
- R2: On the serial clock edge that ends a conversion, `quant_data` is captured. It is shifted out in the frame started by the next convert strobe, so the latency is one conversion. Before any conversion completes, the word is zero.
- R3: The word is shifted most significant bit first as 14 raw two's complement bits. One new bit appears on `sdo` per serial clock rising edge, and `sdo` holds still between edges.
- R4: `sdo_en` is low right after a convert strobe. It rises on the first serial clock rising edge after the strobe, stays high for 14 bits, and falls on the 15th edge. While `sdo_en` is low, `sdo` is 0.
- R5: A second or third convert rising edge with no serial clock edge in between puts the block in nap (`nap`=1). The conversion in progress is abandoned, and `hold` and `sdo_en` go low.
- R6: A fourth or later convert rising edge with no serial clock edge in between enters sleep (`sleep`=1, `nap`=0). Further strobes leave the block in sleep.
- R7: Any serial clock rising edge during sleep returns the block to run. That edge neither shifts data nor advances a conversion.
- R8: In nap, a serial clock edge with no convert strobe since nap was entered is ignored. A convert strobe followed by a serial clock edge returns the block to run.
- R9: A serial clock rising edge clears the strobe count, so convert strobes separated by serial clock activity each start a normal conversion.
- R10: After the synchronous reset, `hold`, `sdo_en`, `sdo`, `nap` and `sleep` are all 0.
- R11: While `nap` or `sleep` is high, `sdo_en` and `hold` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_in | input | 1 | Asynchronous convert-start strobe |
| sck_in | input | 1 | Asynchronous serial clock |
| quant_data | input | 14 | Quantizer result bus, two's complement |
| sdo | output | 1 | Serial data bit |
| sdo_en | output | 1 | Drive enable for the three-state data pad |
| hold | output | 1 | Sample-and-hold command, high while converting |
| nap | output | 1 | Nap state flag |
| sleep | output | 1 | Sleep state flag |

## Verification
A table of quantizer words drives back-to-back frames. The words are the largest positive, the most negative, minus one and alternating bit patterns. These reveal bit-order reversal, sign handling and an off-by-one in the one-conversion latency, because each frame must return the word of the frame before it. Directed strobe trains of one, two, three, four and five pulses, with the serial clock held still, separate the nap and sleep thresholds. Strobes separated by a serial clock pulse show that the count is cleared. After each wake-up, a frame must return the last completed word, which shows that cancelled conversions leave the result untouched and that the waking edge shifts no data.

// File: rtl/adcctl_pkg.sv
package adcctl_pkg;
  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_NAP   = 2'd1,
    PWR_SLEEP = 2'd2
  } pwr_e;
endpackage

// File: rtl/adcctl_edge_sync.sv
module adcctl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], din};
  end

  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/adcctl_power.sv
module adcctl_power
  import adcctl_pkg::*;
#(
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic conv_rise,
  input  logic sck_rise,
  output pwr_e pwr,
  output logic conv_go,
  output logic sck_go,
  output logic cancel
);
  localparam int CNT_W = $clog2(SLEEP_PULSES + 1);
  localparam logic [CNT_W-1:0] NAP_C   = CNT_W'(NAP_PULSES);
  localparam logic [CNT_W-1:0] SLEEP_C = CNT_W'(SLEEP_PULSES);

  logic [CNT_W-1:0] cnt, cnt_n;
  logic             wake_armed;

  assign cnt_n   = (cnt == SLEEP_C) ? cnt : cnt + 1'b1;
  assign conv_go = conv_rise && (pwr == PWR_RUN) && (cnt_n < NAP_C);
  assign cancel  = conv_rise && (pwr == PWR_RUN) && (cnt_n >= NAP_C);
  assign sck_go  = sck_rise && !conv_rise && (pwr == PWR_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr        <= PWR_RUN;
      cnt        <= '0;
      wake_armed <= 1'b0;
    end else if (conv_rise) begin
      cnt <= cnt_n;
      case (pwr)
        PWR_RUN: begin
          if (cnt_n >= SLEEP_C)    pwr <= PWR_SLEEP;
          else if (cnt_n >= NAP_C) pwr <= PWR_NAP;
          wake_armed <= 1'b0;
        end
        PWR_NAP: begin
          wake_armed <= 1'b1;
          if (cnt_n >= SLEEP_C) pwr <= PWR_SLEEP;
        end
        default: pwr <= PWR_SLEEP;
      endcase
    end else if (sck_rise) begin
      cnt <= '0;
      case (pwr)
        PWR_SLEEP: pwr <= PWR_RUN;
        PWR_NAP: if (wake_armed) begin
          pwr        <= PWR_RUN;
          wake_armed <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adcctl_sequencer.sv
module adcctl_sequencer #(
  parameter int DATA_W     = 14,
  parameter int CONV_STEPS = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_go,
  input  logic              sck_go,
  input  logic              cancel,
  input  logic [DATA_W-1:0] din,
  output logic              hold,
  output logic [DATA_W-1:0] result
);
  localparam int STEP_W = $clog2(CONV_STEPS + 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(CONV_STEPS - 1);

  logic [STEP_W-1:0] step;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold   <= 1'b0;
      step   <= '0;
      result <= '0;
    end else if (cancel) begin
      hold <= 1'b0;
      step <= '0;
    end else if (conv_go) begin
      hold <= 1'b1;
      step <= '0;
    end else if (sck_go && hold) begin
      if (step == LAST_STEP) begin
        hold   <= 1'b0;
        step   <= '0;
        result <= din;
      end else begin
        step <= step + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adcctl_shifter.sv
module adcctl_shifter #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_go,
  input  logic              sck_go,
  input  logic              cancel,
  input  logic [DATA_W-1:0] word,
  output logic              sdo,
  output logic              sdo_en
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] shreg;
  logic [BIT_W-1:0]  bitc;
  logic              armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      bitc   <= '0;
      armed  <= 1'b0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (cancel) begin
      armed  <= 1'b0;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (conv_go) begin
      shreg  <= word;
      bitc   <= '0;
      armed  <= 1'b1;
      sdo    <= 1'b0;
      sdo_en <= 1'b0;
    end else if (sck_go) begin
      if (armed) begin
        armed  <= 1'b0;
        sdo_en <= 1'b1;
        sdo    <= shreg[DATA_W-1];
        shreg  <= shreg << 1;
        bitc   <= '0;
      end else if (sdo_en) begin
        if (bitc == LAST_BIT) begin
          sdo_en <= 1'b0;
          sdo    <= 1'b0;
        end else begin
          bitc  <= bitc + 1'b1;
          sdo   <= shreg[DATA_W-1];
          shreg <= shreg << 1;
        end
      end
    end
  end
endmodule

// File: rtl/adcctl_top.sv
module adcctl_top
  import adcctl_pkg::*;
#(
  parameter int DATA_W       = 14,
  parameter int CONV_STEPS   = 14,
  parameter int SYNC_STAGES  = 2,
  parameter int NAP_PULSES   = 2,
  parameter int SLEEP_PULSES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_in,
  input  logic              sck_in,
  input  logic [DATA_W-1:0] quant_data,
  output logic              sdo,
  output logic              sdo_en,
  output logic              hold,
  output logic              nap,
  output logic              sleep
);
  logic              conv_rise, sck_rise;
  logic              conv_go, sck_go, cancel;
  logic [DATA_W-1:0] result;
  pwr_e              pwr;

  adcctl_edge_sync #(.STAGES(SYNC_STAGES)) u_conv_sync (
    .clk(clk), .rst(rst), .din(conv_in), .rise(conv_rise));

  adcctl_edge_sync #(.STAGES(SYNC_STAGES)) u_sck_sync (
    .clk(clk), .rst(rst), .din(sck_in), .rise(sck_rise));

  adcctl_power #(.NAP_PULSES(NAP_PULSES), .SLEEP_PULSES(SLEEP_PULSES)) u_power (
    .clk(clk), .rst(rst), .conv_rise(conv_rise), .sck_rise(sck_rise),
    .pwr(pwr), .conv_go(conv_go), .sck_go(sck_go), .cancel(cancel));

  adcctl_sequencer #(.DATA_W(DATA_W), .CONV_STEPS(CONV_STEPS)) u_seq (
    .clk(clk), .rst(rst), .conv_go(conv_go), .sck_go(sck_go), .cancel(cancel),
    .din(quant_data), .hold(hold), .result(result));

  adcctl_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .conv_go(conv_go), .sck_go(sck_go), .cancel(cancel),
    .word(result), .sdo(sdo), .sdo_en(sdo_en));

  assign nap   = (pwr == PWR_NAP);
  assign sleep = (pwr == PWR_SLEEP);
endmodule

// File: rtl/adcctl_checks.sv
module adcctl_checks (
  input logic clk,
  input logic rst,
  input logic conv_rise,
  input logic sck_rise,
  input logic hold,
  input logic sdo,
  input logic sdo_en,
  input logic nap,
  input logic sleep
);
  p_hold_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(hold) |-> $past(conv_rise));

  p_bit_steady_r3: assert property (@(posedge clk) disable iff (rst)
    (sdo_en && $past(sdo_en) && !$past(sck_rise)) |-> $stable(sdo));

  p_en_start_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_en) |-> $past(sck_rise));

  p_nap_entry_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(nap) |-> $past(conv_rise));

  p_sleep_entry_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sleep) |-> $past(conv_rise));

  p_sleep_wake_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep) |-> $past(sck_rise));

  p_quiet_power_r11: assert property (@(posedge clk) disable iff (rst)
    (nap || sleep) |-> (!sdo_en && !hold));
endmodule

bind adcctl_top adcctl_checks u_checks (
  .clk(clk), .rst(rst), .conv_rise(conv_rise), .sck_rise(sck_rise),
  .hold(hold), .sdo(sdo), .sdo_en(sdo_en), .nap(nap), .sleep(sleep));

// File: tb/adcctl_top_test.sv
module adcctl_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int NVEC       = 6;
  localparam logic [13:0] VEC [NVEC] = '{
    14'h1FFF, 14'h2000, 14'h3FFF, 14'h0001, 14'h2AAA, 14'h1555};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_in = 1'b0;
  logic        sck_in = 1'b0;
  logic [13:0] quant_data = '0;
  logic        sdo, sdo_en, hold, nap, sleep;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [13:0] last_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcctl_top uut (
    .clk(clk), .rst(rst), .conv_in(conv_in), .sck_in(sck_in),
    .quant_data(quant_data), .sdo(sdo), .sdo_en(sdo_en), .hold(hold),
    .nap(nap), .sleep(sleep));

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_conv();
    @(negedge clk) conv_in = 1'b1;
    repeat (HALF) @(negedge clk);
    conv_in = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic pulse_sck();
    @(negedge clk) sck_in = 1'b1;
    repeat (HALF) @(negedge clk);
    sck_in = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  // one full frame: strobe, 14 data edges, one release edge
  task automatic run_frame(input logic [13:0] q, input logic [13:0] exp_word);
    logic [13:0] word;
    quant_data = q;
    pulse_conv();
    chk("R1 hold after strobe", 32'(hold), 32'd1);
    chk("R4 enable low after strobe", 32'(sdo_en), 32'd0);
    word = '0;
    for (int k = 0; k < 14; k++) begin
      pulse_sck();
      if (k == 0) chk("R4 enable on first edge", 32'(sdo_en), 32'd1);
      word = {word[12:0], sdo};
    end
    chk("R2 R3 word msb first", 32'(word), 32'(exp_word));
    chk("R1 hold low after last step", 32'(hold), 32'd0);
    pulse_sck();
    chk("R4 enable low after 15th edge", 32'(sdo_en), 32'd0);
    chk("R4 sdo zero when released", 32'(sdo), 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R10 hold", 32'(hold), 32'd0);
    chk("R10 sdo_en", 32'(sdo_en), 32'd0);
    chk("R10 sdo", 32'(sdo), 32'd0);
    chk("R10 nap sleep", 32'({nap, sleep}), 32'd0);
    @(negedge clk) rst = 1'b0;
    repeat (4) @(negedge clk);

    // vector walk: each frame returns the previous capture
    last_word = '0;
    for (int i = 0; i < NVEC; i++) begin
      run_frame(VEC[i], last_word);
      last_word = VEC[i];
    end

    // R9: a serial clock edge between strobes clears the count
    quant_data = 14'h0ABC;
    pulse_conv();
    pulse_sck();
    pulse_conv();
    chk("R9 no nap with edge between strobes", 32'(nap), 32'd0);
    chk("R9 second strobe restarts conversion", 32'(hold), 32'd1);
    repeat (15) pulse_sck();
    last_word = 14'h0ABC;

    // R5 / R8: nap entry and wake
    quant_data = 14'h1234;
    pulse_conv();
    pulse_conv();
    chk("R5 nap after two strobes", 32'(nap), 32'd1);
    chk("R5 hold abandoned", 32'(hold), 32'd0);
    chk("R5 enable low in nap", 32'(sdo_en), 32'd0);
    pulse_sck();
    chk("R8 lone edge ignored in nap", 32'(nap), 32'd1);
    chk("R8 no data from lone edge", 32'(sdo_en), 32'd0);
    pulse_conv();
    chk("R8 strobe keeps nap", 32'(nap), 32'd1);
    pulse_sck();
    chk("R8 strobe then edge wakes", 32'(nap), 32'd0);
    run_frame(14'h0777, last_word);
    last_word = 14'h0777;

    // R5 / R6 / R7: three strobes nap, four sleep, more stay asleep
    pulse_conv();
    pulse_conv();
    pulse_conv();
    chk("R5 three strobes still nap", 32'({nap, sleep}), 32'b10);
    pulse_conv();
    chk("R6 four strobes sleep", 32'({nap, sleep}), 32'b01);
    chk("R11 hold low in sleep", 32'(hold), 32'd0);
    pulse_conv();
    chk("R6 fifth strobe stays asleep", 32'({nap, sleep}), 32'b01);
    pulse_sck();
    chk("R7 edge wakes from sleep", 32'({nap, sleep}), 32'b00);
    chk("R7 waking edge shifts nothing", 32'(sdo_en), 32'd0);
    run_frame(14'h0000, last_word);

    summary();
  end
endmodule